// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer. A 32-bit up-counter advances on ticks from a programmable prescaler. When the counter wraps past its all-ones value, the block raises a one-cycle reset pulse and reloads the counter from the load register. Software keeps the system alive by writing changing values to the trigger register. Each new trigger value reloads the counter before it can wrap.

Software can start or stop the counter only with a two-write key sequence sent to the key register. The control, counter and load registers accept configuration only while the counter is stopped. A load value written while the timer runs is therefore lost, and the running timeout cannot be shortened or stretched by accident.

Register writes are posted. Each writable register has a pending flag that stays set for a fixed latency before the write takes effect. This latency stands in for a crossing into a slower timer clock. A write that arrives while its register is still pending waits in a one-entry holding slot.

Top module: `keyseq_wdt`

## Requirements
- R1: The counter starts running only after the key register (address 4) takes effect with 0x0000BBBB and then directly with 0x00004444. Address 4 reads back 1 in bit 0 while running and 0 while stopped.
- R2: A running counter stops only after the key register takes effect with 0x0000AAAA and then directly with 0x00005555. Once stopped, the counter value holds.
- R3: If the key write that follows a first key is not the matching second key, the partial sequence is abandoned. This includes a repeat of the first key. The run state is unchanged, and a later lone second key does nothing.
- R4: The control register (address 0) keeps only bits [5:2]; other bits read 0. Bits [4:2] hold a ratio P. When bit 5 is set, the counter advances once every 2^P clocks. When bit 5 is clear, it advances every clock whatever P holds.
- R5: While running, the counter (readable at address 1) increases by one per prescaler tick, starting from the value it was reloaded or written with.
- R6: A write to the trigger register (address 3) whose value differs from the last trigger value reloads the counter with the effective load value (address 2). A write that repeats the last value leaves the counter untouched.
- R7: Writes to the control, counter and load registers that take effect while the counter runs are discarded. The running count rate, the count and the load value used by later reloads all stay as they were.
- R8: When the counter advances from 0xFFFFFFFF, wdt_rst_o is high for exactly one cycle and the counter reloads from the load value. With no prescaling this repeats every 2^32 minus load cycles.
- R9: A write sets its pending bit in the status register (address 5) in the next cycle. The bits are: bit 0 control, bit 1 counter, bit 2 load, bit 3 trigger, bit 4 key. The write takes effect and the bit clears four cycles after the write is sampled.
- R10: A second write to a register whose bit is still pending is held. It takes effect four cycles after the first write takes effect, and the pending bit stays set in between.
- R11: After reset the counter is stopped, all registers read 0, no bit is pending, and wdt_rst_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data, one cycle after rd_addr |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a four-cycle posting latency and a 3-bit prescaler ratio. With a 32-bit counter, a wrap can only be reached in a short run by loading a value just below all-ones. The bench uses 0xFFFFFFF0, so two reset pulses arrive 16 cycles apart. With ratio 2 and a 40-cycle read window, the divided rate shows up as an exact count difference of 10. The four-cycle latency lets the bench see the holding slot between the first and second commit of a back-to-back write pair.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NREG = 5;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_LOAD  = 3'd2,
    A_TRIG  = 3'd3,
    A_KEY   = 3'd4,
    A_PEND  = 3'd5
  } wdt_addr_e;

  localparam logic [15:0] KEY_RUN_1  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN_2  = 16'h4444;
  localparam logic [15:0] KEY_HALT_1 = 16'hAAAA;
  localparam logic [15:0] KEY_HALT_2 = 16'h5555;

  localparam int CTRL_PTV_LSB = 2;
  localparam int CTRL_PEN_BIT = 5;

  typedef enum logic [1:0] {
    K_IDLE,
    K_RUN_WAIT,
    K_HALT_WAIT
  } key_state_e;
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
  parameter int DW  = 32,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          commit_o,
  output logic [DW-1:0] cdata_o,
  output logic          pend_o
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          hv_q;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
      hv_q   <= 1'b0;
      hold_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (hv_q) begin
          data_q <= hold_q;
          cnt_q  <= CNT_INIT;
          if (wr_i) hold_q <= wdata_i;
          else      hv_q   <= 1'b0;
        end else if (wr_i) begin
          data_q <= wdata_i;
          cnt_q  <= CNT_INIT;
        end else begin
          busy_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (wr_i) begin
          hv_q   <= 1'b1;
          hold_q <= wdata_i;
        end
      end
    end else if (wr_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_INIT;
      data_q <= wdata_i;
    end
  end

  assign commit_o = busy_q && (cnt_q == '0);
  assign cdata_o  = data_q;
  assign pend_o   = busy_q;

  // R9: a commit is never earlier than one cycle after the slot went busy
  a_r9_commit_waits: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(busy_q));
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit_i,
  input  logic [DW-1:0] key_i,
  output logic          run_o
);
  import wdt_pkg::*;

  key_state_e st_q;
  logic       run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= K_IDLE;
      run_q <= 1'b0;
    end else if (commit_i) begin
      case (st_q)
        K_IDLE: begin
          if (key_i == DW'(KEY_RUN_1))       st_q <= K_RUN_WAIT;
          else if (key_i == DW'(KEY_HALT_1)) st_q <= K_HALT_WAIT;
        end
        K_RUN_WAIT: begin
          st_q <= K_IDLE;
          if (key_i == DW'(KEY_RUN_2)) run_q <= 1'b1;
        end
        K_HALT_WAIT: begin
          st_q <= K_IDLE;
          if (key_i == DW'(KEY_HALT_2)) run_q <= 1'b0;
        end
        default: st_q <= K_IDLE;
      endcase
    end
  end

  assign run_o = run_q;

  // R1: running only begins from the state that saw the first start key
  a_r1_start_after_first_key: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(st_q == K_RUN_WAIT));
  // R2: stopping only happens from the state that saw the first stop key
  a_r2_stop_after_first_key: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(st_q == K_HALT_WAIT));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             en_i,
  input  logic [PTV_W-1:0] ptv_i,
  output logic             tick_o
);
  localparam int DIVW = (1 << PTV_W) - 1;

  logic [DIVW-1:0] div_q;
  logic [DIVW:0]   one_sh;
  logic [DIVW-1:0] mask;

  always_comb begin
    one_sh = (DIVW + 1)'(1) << ptv_i;
    mask   = one_sh[DIVW-1:0] - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (!en_i || ((div_q & mask) == mask));

  // R4: no tick is produced while the timer is stopped
  a_r4_tick_needs_run: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> run_i);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          cnt_wr_i,
  input  logic [DW-1:0] cnt_data_i,
  input  logic          load_wr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          trig_wr_i,
  input  logic [DW-1:0] trig_data_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] trig_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] load_q;
  logic [DW-1:0] trig_q;
  logic          wrap_q;
  logic          reload;

  assign reload = trig_wr_i && (trig_data_i != trig_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
      trig_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (load_wr_i && !run_i) load_q <= load_data_i;
      if (trig_wr_i)           trig_q <= trig_data_i;
      if (reload) begin
        cnt_q <= load_q;
      end else if (cnt_wr_i && !run_i) begin
        cnt_q <= cnt_data_i;
      end else if (tick_i) begin
        if (cnt_q == '1) begin
          cnt_q  <= load_q;
          wrap_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign trig_o = trig_q;
  assign wrap_o = wrap_q;

  // R7: the load value never moves across a cycle spent running
  a_r7_load_locked: assert property (@(posedge clk) disable iff (rst)
    (run_i && $past(run_i)) |-> $stable(load_q));
  // R8: the reset pulse coincides with the counter holding the load value
  a_r8_wrap_reloads: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (cnt_q == load_q));
endmodule

// File: rtl/keyseq_wdt.sv
module keyseq_wdt #(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int LAT   = 4,
  parameter int PTV_W = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          wdt_rst_o
);
  import wdt_pkg::*;

  localparam logic [DW-1:0] CTRL_MASK =
    DW'(((1 << (PTV_W + 1)) - 1) << CTRL_PTV_LSB);

  logic [NREG-1:0] slot_wr;
  logic [NREG-1:0] slot_commit;
  logic [NREG-1:0] slot_pend;
  logic [DW-1:0]   slot_data [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    assign slot_wr[g] = wr_en && (wr_addr == AW'(g));
    wdt_post_slot #(.DW(DW), .LAT(LAT)) slot_i (
      .clk      (clk),
      .rst      (rst),
      .wr_i     (slot_wr[g]),
      .wdata_i  (wr_data),
      .commit_o (slot_commit[g]),
      .cdata_o  (slot_data[g]),
      .pend_o   (slot_pend[g])
    );
  end

  logic run;
  wdt_keyseq #(.DW(DW)) key_i (
    .clk      (clk),
    .rst      (rst),
    .commit_i (slot_commit[A_KEY]),
    .key_i    (slot_data[A_KEY]),
    .run_o    (run)
  );

  logic [DW-1:0] ctrl_q;
  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= '0;
    else if (slot_commit[A_CTRL] && !run)   ctrl_q <= slot_data[A_CTRL] & CTRL_MASK;
  end

  logic tick;
  wdt_prescale #(.PTV_W(PTV_W)) pre_i (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .en_i   (ctrl_q[CTRL_PTV_LSB + PTV_W]),
    .ptv_i  (ctrl_q[CTRL_PTV_LSB +: PTV_W]),
    .tick_o (tick)
  );

  logic [DW-1:0] cnt_v, load_v, trig_v;
  logic          wrap;
  wdt_count #(.DW(DW)) cnt_i (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .tick_i      (tick),
    .cnt_wr_i    (slot_commit[A_COUNT]),
    .cnt_data_i  (slot_data[A_COUNT]),
    .load_wr_i   (slot_commit[A_LOAD]),
    .load_data_i (slot_data[A_LOAD]),
    .trig_wr_i   (slot_commit[A_TRIG]),
    .trig_data_i (slot_data[A_TRIG]),
    .cnt_o       (cnt_v),
    .load_o      (load_v),
    .trig_o      (trig_v),
    .wrap_o      (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        AW'(A_CTRL):  rd_data <= ctrl_q;
        AW'(A_COUNT): rd_data <= cnt_v;
        AW'(A_LOAD):  rd_data <= load_v;
        AW'(A_TRIG):  rd_data <= trig_v;
        AW'(A_KEY):   rd_data <= DW'(run);
        AW'(A_PEND):  rd_data <= DW'(slot_pend);
        default:      rd_data <= '0;
      endcase
    end
  end

  assign wdt_rst_o = wrap;

  // R7: control settings cannot move while running
  a_r7_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(ctrl_q));
endmodule

// File: tb/keyseq_wdt_tb_top.sv
`timescale 1ns/1ps
module keyseq_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wdt_rst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  keyseq_wdt dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wdt_rst_o(wdt_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_true(input string req, input bit ok, input logic [31:0] act,
                            input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic key(input logic [31:0] d);
    wr(3'd4, d);
    idle(6);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd5, v); check("R11 pend", v, 32'h0);
    rd(3'd4, v); check("R11 run", v, 32'h0);
    rd(3'd1, v); check("R11 count", v, 32'h0);
    rd(3'd2, v); check("R11 load", v, 32'h0);
    check("R11 rst_o", {31'b0, wdt_rst_o}, 32'h0);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    wr(3'd0, 32'h0);
    rd(3'd5, v); check("R9 pend set", v, 32'h1);
    idle(6);
    rd(3'd5, v); check("R9 pend clear", v, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    wr(3'd2, 32'h11);
    wr(3'd2, 32'h22);
    idle(3);
    rd(3'd2, v); check("R10 first commit", v, 32'h11);
    rd(3'd5, v); check("R10 still pending", v, 32'h4);
    idle(6);
    rd(3'd2, v); check("R10 held commit", v, 32'h22);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr(3'd2, 32'hFF00_0000); idle(6);
    wr(3'd1, 32'h5); idle(6);
    rd(3'd1, v); check("R6 count write", v, 32'h5);
    wr(3'd3, 32'h1234); idle(6);
    rd(3'd1, v); check("R6 reload new", v, 32'hFF00_0000);
    wr(3'd1, 32'h5); idle(6);
    wr(3'd3, 32'h1234); idle(6);
    rd(3'd1, v); check("R6 same value ignored", v, 32'h5);
    wr(3'd3, 32'h4321); idle(6);
    rd(3'd1, v); check("R6 reload again", v, 32'hFF00_0000);
  endtask

  task automatic t_start();
    logic [31:0] v, a, b;
    key(32'hBBBB); key(32'h4444);
    rd(3'd4, v); check("R1 running", v, 32'h1);
    rd(3'd1, a);
    check_true("R5 counts up from load", a > 32'hFF00_0000 && a < 32'hFF00_0100, a, 32'hFF00_0000);
    idle(9);
    rd(3'd1, b); check("R5 one per tick", b - a, 32'd10);
  endtask

  task automatic t_locked();
    logic [31:0] v, a, b;
    wr(3'd2, 32'h0); idle(6);
    wr(3'd0, 32'h28); idle(6);
    wr(3'd1, 32'h7); idle(6);
    rd(3'd2, v); check("R7 load kept", v, 32'hFF00_0000);
    rd(3'd0, v); check("R7 ctrl kept", v, 32'h0);
    rd(3'd1, a); idle(9);
    rd(3'd1, b); check("R7 rate kept", b - a, 32'd10);
    wr(3'd3, 32'h9999); idle(6);
    rd(3'd1, v);
    check_true("R7 reload uses old load", v >= 32'hFF00_0000 && v < 32'hFF00_0010, v, 32'hFF00_0000);
  endtask

  task automatic t_stop();
    logic [31:0] v, a, b;
    key(32'hAAAA); key(32'h5555);
    rd(3'd4, v); check("R2 stopped", v, 32'h0);
    rd(3'd1, a); idle(9);
    rd(3'd1, b); check("R2 count holds", b, a);
  endtask

  task automatic t_badkey();
    logic [31:0] v;
    key(32'hBBBB); key(32'h1234); key(32'h4444);
    rd(3'd4, v); check("R3 broken start", v, 32'h0);
    key(32'hBBBB); key(32'hBBBB); key(32'h4444);
    rd(3'd4, v); check("R3 repeated first key", v, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v, a, b;
    wr(3'd0, 32'hFFFF_FFE8); idle(6);
    rd(3'd0, v); check("R4 ctrl bits kept", v, 32'h28);
    key(32'hBBBB); key(32'h4444);
    rd(3'd1, a); idle(39);
    rd(3'd1, b); check("R4 divide by 4", b - a, 32'd10);
    key(32'hAAAA); key(32'h5555);
    wr(3'd0, 32'h08); idle(6);
    key(32'hBBBB); key(32'h4444);
    rd(3'd1, a); idle(9);
    rd(3'd1, b); check("R4 enable clear", b - a, 32'd10);
    key(32'hAAAA); key(32'h5555);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int p1, p2;
    p1 = -1; p2 = -1;
    wr(3'd0, 32'h0); idle(6);
    wr(3'd2, 32'hFFFF_FFF0); idle(6);
    wr(3'd3, 32'h5555_0001); idle(6);
    rd(3'd1, v); check("R8 preload", v, 32'hFFFF_FFF0);
    key(32'hBBBB);
    wr(3'd4, 32'h4444);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (wdt_rst_o) begin
        if (p1 < 0) p1 = i;
        else if (p2 < 0) p2 = i;
      end
      if (p1 >= 0 && i == p1 + 1)
        check("R8 pulse width", {31'b0, wdt_rst_o}, 32'h0);
    end
    check_true("R8 pulse seen", p1 >= 0, 32'(p1), 32'h0);
    check("R8 period", 32'(p2 - p1), 32'd16);
    key(32'hAAAA); key(32'h5555);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_pending();
    t_hold();
    t_trigger();
    t_start();
    t_locked();
    t_stop();
    t_badkey();
    t_prescale();
    t_wrap();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule